// File: doc/BRIEF.md
# Temperature Threshold Compare Unit

This unit sits behind a temperature converter. Each time the converter reports a finished conversion, the unit stores the new signed 13-bit reading in a read-only result word. In the same cycle it compares the reading against three limits that the host programs: a window top, a window bottom and a critical ceiling. The three results of that comparison go into the top three bits of the result word. Between conversion strobes the result word and its trip bits stay frozen. A host that reads during a conversion therefore sees the previous result.

The host reaches eight 16-bit words through a pointer. A pointer write picks a word. A data write then updates that word if it is writable, and the read port always shows the word under the pointer. An alert output is derived from the trip bits. Configuration gates the alert, sets its active level, and chooses between two behaviours: the alert either follows the stored trip bits, or it latches until the host clears it. A shutdown bit stops captures and keeps the last result.

Top module: `temp_limit_monitor`

## Requirements
- R1: After reset the pointer selects word 0 (capability), so `dataOut` equals the capability parameter. The configuration word and all three limits are 0x0000, and `eventOut` is high, the inactive level for the default polarity.
- R2: Word map by pointer: 0 capability (read-only parameter), 1 configuration, 2 window top, 3 window bottom, 4 critical ceiling, 5 result (read-only), 6 identity (read-only parameter), 7 reserved (reads 0x0000). `dataOut` shows the selected word in the same cycle, without a clock edge.
- R3: On a cycle with `convDone` high and shutdown clear, result bits 12:0 take `convSample`, and the new value is readable after that clock edge.
- R4: Without a capture, the result word, including its trip bits, keeps its value even when the limits are rewritten.
- R5: Limit words keep only bits 12:2; bits 15:13 and 1:0 read back as zero. Bits 12:0 of a limit, read as a 13-bit two's complement number, are compared on the same 0.0625 °C scale as the reading. This puts the limit LSB at 0.25 °C.
- R6: At capture, bit 15 = reading > critical, bit 14 = reading > window top, bit 13 = reading < window bottom. All comparisons are signed and strict. No configuration bit affects them.
- R7: Writes to the capability, result, identity and reserved words change nothing.
- R8: Configuration bit 8 (shutdown) blocks captures, and the result word keeps its last value.
- R9: Configuration bit 0 enables the alert. With bit 1 = 0 (follow mode), the alert is active while the enable is set and any trip bit of the result word is 1.
- R10: With bit 1 = 1 (latch mode), a capture that has any trip set while the enable is on latches the alert. The latch holds through later clean captures. A configuration write with bit 3 set clears it. A new trip in the same cycle beats the clear. Bit 3 is not stored and reads 0.
- R11: Configuration bit 2 = 1 makes the active alert level high; 0 makes it low. While the alert is inactive or disabled, `eventOut` sits at the opposite level.
- R12: The identity word returns the ID parameter. Its low byte, the revision, defaults to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | One-cycle strobe: a conversion finished |
| convSample | input | 13 | Signed reading, 0.0625 °C per LSB |
| ptrWrEn | input | 1 | Load the word pointer |
| ptrIn | input | 3 | New pointer value |
| dataWrEn | input | 1 | Write `dataIn` to the word under the pointer |
| dataIn | input | 16 | Host write data |
| dataOut | output | 16 | Word under the pointer |
| eventOut | output | 1 | Alert output |

## Verification
The bench sweeps readings across the full signed range against two limit sets, one positive and one spanning negative values. It hits the exact limit value and the value one step beyond each limit. An unsigned compare would mark negative readings as above the window. A compare off by the 4x scale would move every trip boundary. A non-strict compare would fail at the exact limit. The bench also rewrites limits without a strobe, so a design that compares continuously would show changed trip bits. It writes to read-only words, which exposes any stray write decode. It tests the latch against later clean captures and against its clear, and checks the alert at both polarity settings.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef enum logic [2:0] {
    W_CAP   = 3'd0,
    W_CFG   = 3'd1,
    W_UPPER = 3'd2,
    W_LOWER = 3'd3,
    W_CRIT  = 3'd4,
    W_VALUE = 3'd5,
    W_ID    = 3'd6,
    W_RSVD  = 3'd7
  } word_sel_e;

  typedef struct packed {
    logic capture;
    logic wrCfg;
    logic wrUpper;
    logic wrLower;
    logic wrCrit;
  } tlm_strobe_t;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_MODE_BIT = 1;
  localparam int CFG_POL_BIT  = 2;
  localparam int CFG_CLR_BIT  = 3;
  localparam int CFG_SHDN_BIT = 8;
endpackage

// File: rtl/tlm_datapath.sv
module tlm_datapath
  import tlm_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int REG_W    = 16,
  parameter int LIM_DROP = 2,
  parameter logic [REG_W-1:0] CAP_WORD = 16'h0001,
  parameter logic [REG_W-1:0] ID_WORD  = 16'h0C00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tlm_strobe_t         stb,
  input  logic [2:0]          ptr,
  input  logic [SAMPLE_W-1:0] convSample,
  input  logic [REG_W-1:0]    dataIn,
  output logic [REG_W-1:0]    dataOut,
  output logic [REG_W-1:0]    cfgWord,
  output logic [2:0]          trips,
  output logic                nextAny
);
  localparam logic [REG_W-1:0] SAMPLE_MASK = REG_W'((1 << SAMPLE_W) - 1);
  localparam logic [REG_W-1:0] LIM_MASK =
    SAMPLE_MASK & ~REG_W'((1 << LIM_DROP) - 1);
  localparam logic [REG_W-1:0] CFG_MASK =
    REG_W'((1 << CFG_EN_BIT) | (1 << CFG_MODE_BIT) | (1 << CFG_POL_BIT) | (1 << CFG_SHDN_BIT));

  logic [REG_W-1:0] cfgReg, upperReg, lowerReg, critReg, valueReg;
  logic             overCrit, overUpper, underLower;
  logic signed [SAMPLE_W-1:0] sSample, sUpper, sLower, sCrit;

  assign sSample = $signed(convSample);
  assign sUpper  = $signed(upperReg[SAMPLE_W-1:0]);
  assign sLower  = $signed(lowerReg[SAMPLE_W-1:0]);
  assign sCrit   = $signed(critReg[SAMPLE_W-1:0]);

  assign overCrit   = sSample > sCrit;
  assign overUpper  = sSample > sUpper;
  assign underLower = sSample < sLower;
  assign nextAny    = overCrit | overUpper | underLower;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgReg   <= '0;
      upperReg <= '0;
      lowerReg <= '0;
      critReg  <= '0;
      valueReg <= '0;
    end else begin
      if (stb.wrCfg)   cfgReg   <= dataIn & CFG_MASK;
      if (stb.wrUpper) upperReg <= dataIn & LIM_MASK;
      if (stb.wrLower) lowerReg <= dataIn & LIM_MASK;
      if (stb.wrCrit)  critReg  <= dataIn & LIM_MASK;
      if (stb.capture) begin
        valueReg <= '0;
        valueReg[SAMPLE_W-1:0] <= convSample;
        valueReg[REG_W-1]      <= overCrit;
        valueReg[REG_W-2]      <= overUpper;
        valueReg[REG_W-3]      <= underLower;
      end
    end
  end

  assign cfgWord = cfgReg;
  assign trips   = valueReg[REG_W-1:REG_W-3];

  always_comb begin
    case (word_sel_e'(ptr))
      W_CAP:   dataOut = CAP_WORD;
      W_CFG:   dataOut = cfgReg;
      W_UPPER: dataOut = upperReg;
      W_LOWER: dataOut = lowerReg;
      W_CRIT:  dataOut = critReg;
      W_VALUE: dataOut = valueReg;
      W_ID:    dataOut = ID_WORD;
      default: dataOut = '0;
    endcase
  end

  // R3: a capture lands the reading in the low bits
  a_r3_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
    stb.capture |=> valueReg[SAMPLE_W-1:0] == $past(convSample));
  // R4: no capture, no change
  a_r4_value_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.capture |=> $stable(valueReg));
  // R8: shutdown blocks control's capture strobe
  a_r8_shutdown_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfgReg[CFG_SHDN_BIT] |-> !stb.capture);
endmodule

// File: rtl/tlm_control.sv
module tlm_control
  import tlm_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convDone,
  input  logic             ptrWrEn,
  input  logic [2:0]       ptrIn,
  input  logic             dataWrEn,
  input  logic [REG_W-1:0] dataIn,
  input  logic [REG_W-1:0] cfgWord,
  input  logic [2:0]       trips,
  input  logic             nextAny,
  output tlm_strobe_t      stb,
  output logic [2:0]       ptr,
  output logic             eventOut
);
  logic [2:0] ptrReg;
  logic       latched, clrReq, active;
  logic       cfgEn, cfgLatchMode, cfgPolHigh, cfgShdn;

  assign cfgEn        = cfgWord[CFG_EN_BIT];
  assign cfgLatchMode = cfgWord[CFG_MODE_BIT];
  assign cfgPolHigh   = cfgWord[CFG_POL_BIT];
  assign cfgShdn      = cfgWord[CFG_SHDN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       ptrReg <= 3'd0;
    else if (ptrWrEn) ptrReg <= ptrIn;
  end
  assign ptr = ptrReg;

  always_comb begin
    stb         = '0;
    stb.capture = convDone & ~cfgShdn;
    if (dataWrEn) begin
      case (word_sel_e'(ptrReg))
        W_CFG:   stb.wrCfg   = 1'b1;
        W_UPPER: stb.wrUpper = 1'b1;
        W_LOWER: stb.wrLower = 1'b1;
        W_CRIT:  stb.wrCrit  = 1'b1;
        default: ;
      endcase
    end
  end

  assign clrReq = stb.wrCfg & dataIn[CFG_CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)
      latched <= 1'b0;
    else if (stb.capture & cfgEn & cfgLatchMode & nextAny)
      latched <= 1'b1;
    else if (clrReq)
      latched <= 1'b0;
  end

  assign active   = cfgEn & (cfgLatchMode ? latched : |trips);
  assign eventOut = cfgPolHigh ? active : ~active;

  // R10: latch persists until a clear request
  a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !clrReq |=> latched);
  // R9: alert can only move after a capture or a configuration write
  a_r9_alert_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.capture && !stb.wrCfg |=> $stable(eventOut));
endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor
  import tlm_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int REG_W    = 16,
  parameter int LIM_DROP = 2,
  parameter logic [REG_W-1:0] CAP_WORD = 16'h0001,
  parameter logic [REG_W-1:0] ID_WORD  = 16'h0C00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                convDone,
  input  logic [SAMPLE_W-1:0] convSample,
  input  logic                ptrWrEn,
  input  logic [2:0]          ptrIn,
  input  logic                dataWrEn,
  input  logic [REG_W-1:0]    dataIn,
  output logic [REG_W-1:0]    dataOut,
  output logic                eventOut
);
  tlm_strobe_t      stb;
  logic [2:0]       ptr;
  logic [REG_W-1:0] cfgWord;
  logic [2:0]       trips;
  logic             nextAny;

  tlm_control #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .convDone(convDone),
    .ptrWrEn(ptrWrEn), .ptrIn(ptrIn), .dataWrEn(dataWrEn), .dataIn(dataIn),
    .cfgWord(cfgWord), .trips(trips), .nextAny(nextAny),
    .stb(stb), .ptr(ptr), .eventOut(eventOut)
  );

  tlm_datapath #(
    .SAMPLE_W(SAMPLE_W), .REG_W(REG_W), .LIM_DROP(LIM_DROP),
    .CAP_WORD(CAP_WORD), .ID_WORD(ID_WORD)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ptr(ptr),
    .convSample(convSample), .dataIn(dataIn), .dataOut(dataOut),
    .cfgWord(cfgWord), .trips(trips), .nextAny(nextAny)
  );
endmodule

// File: tb/temp_limit_monitor_tb.sv
module temp_limit_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        convDone = 1'b0;
  logic [12:0] convSample = '0;
  logic        ptrWrEn = 1'b0;
  logic [2:0]  ptrIn = '0;
  logic        dataWrEn = 1'b0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        eventOut;

  int total = 0;
  int bad = 0;
  int U, L, C;

  always #5 clk = ~clk;

  temp_limit_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .convDone(convDone), .convSample(convSample),
    .ptrWrEn(ptrWrEn), .ptrIn(ptrIn), .dataWrEn(dataWrEn), .dataIn(dataIn),
    .dataOut(dataOut), .eventOut(eventOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setPtr(input int p);
    @(negedge clk); ptrWrEn = 1'b1; ptrIn = 3'(p);
    @(negedge clk); ptrWrEn = 1'b0;
  endtask

  task automatic writeWord(input int p, input logic [15:0] d);
    setPtr(p);
    dataWrEn = 1'b1; dataIn = d;
    @(negedge clk); dataWrEn = 1'b0;
  endtask

  task automatic readChk(input string tag, input int p, input logic [15:0] exp);
    setPtr(p);
    chk(tag, dataOut, exp);
  endtask

  task automatic convert(input int s);
    @(negedge clk); convDone = 1'b1; convSample = 13'(s);
    @(negedge clk); convDone = 1'b0;
  endtask

  function automatic logic [15:0] limWord(input int q);
    return 16'((q * 4) & 16'h1FFC);
  endfunction

  function automatic logic [15:0] expVal(input int s);
    logic [15:0] w;
    w = {3'b000, 13'(s)};
    w[15] = (s > C * 4);
    w[14] = (s > U * 4);
    w[13] = (s < L * 4);
    return w;
  endfunction

  task automatic setLimits(input int u, input int l, input int c);
    U = u; L = l; C = c;
    writeWord(2, limWord(u));
    writeWord(3, limWord(l));
    writeWord(4, limWord(c));
  endtask

  task automatic sweep(input string tag);
    int pts[6];
    pts = '{U*4, U*4+1, L*4, L*4-1, C*4, C*4+1};
    setPtr(5);
    for (int s = -4096; s <= 4095; s += 5) begin
      convert(s);
      chk(tag, dataOut, expVal(s));
    end
    foreach (pts[i]) begin
      convert(pts[i]);
      chk({tag, " edge"}, dataOut, expVal(pts[i]));
    end
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ptr->cap", dataOut, 16'h0001);
    chk("R1 eventOut idle", {15'd0, eventOut}, 16'd1);
    readChk("R1 cfg", 1, 16'h0000);
    readChk("R1 upper", 2, 16'h0000);
    readChk("R1 lower", 3, 16'h0000);
    readChk("R1 crit", 4, 16'h0000);
    // R2 / R12 map and identity
    readChk("R12 id", 6, 16'h0C00);
    chk("R12 revision", {8'd0, dataOut[7:0]}, 16'h0000);
    readChk("R2 reserved", 7, 16'h0000);
    readChk("R2 cap", 0, 16'h0001);
    // R5 limit masking
    writeWord(2, 16'hFFFF);
    readChk("R5 upper mask", 2, 16'h1FFC);
    // R7 read-only words
    writeWord(0, 16'hABCD); readChk("R7 cap", 0, 16'h0001);
    writeWord(6, 16'hABCD); readChk("R7 id", 6, 16'h0C00);
    writeWord(7, 16'hABCD); readChk("R7 rsvd", 7, 16'h0000);
    convert(123);
    writeWord(5, 16'hFFFF);
    U = -1; L = 0; C = 0;
    readChk("R7 value", 5, 16'h0000 | expVal(123));
    // R3 R5 R6 sweeps
    setLimits(100, -40, 340);
    sweep("R6 set A");
    setLimits(-8, -20, 0);
    sweep("R6 set B");
    // R4 hold despite limit rewrite
    convert(-200);
    held = expVal(-200);
    setLimits(1000, -1000, 1000);
    readChk("R4 hold", 5, held);
    // R8 shutdown
    writeWord(1, 16'h0100);
    convert(55);
    readChk("R8 shutdown keep", 5, held);
    writeWord(1, 16'h0000);
    convert(55);
    readChk("R3 resume", 5, expVal(55));
    // R9 follow mode, R11 polarity
    setLimits(10, -10, 200);
    writeWord(1, 16'h0005);
    convert(100);
    chk("R9 follow trip", {15'd0, eventOut}, 16'd1);
    convert(0);
    chk("R9 follow clean", {15'd0, eventOut}, 16'd0);
    writeWord(1, 16'h0001);
    chk("R11 active-low idle", {15'd0, eventOut}, 16'd1);
    convert(-100);
    chk("R11 active-low trip", {15'd0, eventOut}, 16'd0);
    writeWord(1, 16'h0004);
    chk("R11 disabled", {15'd0, eventOut}, 16'd0);
    // R10 latch mode
    writeWord(1, 16'h0007);
    convert(0);
    chk("R10 no trip", {15'd0, eventOut}, 16'd0);
    convert(500);
    chk("R10 latch set", {15'd0, eventOut}, 16'd1);
    convert(0);
    chk("R10 latch holds", {15'd0, eventOut}, 16'd1);
    readChk("R10 clr bit reads 0", 1, 16'h0007);
    writeWord(1, 16'h000F);
    chk("R10 cleared", {15'd0, eventOut}, 16'd0);
    readChk("R10 cfg after clr", 1, 16'h0007);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule